// File: doc/BRIEF.md
# Serial Control Port for a Stereo Audio Processor

This block is the write-only control front end of a stereo audio processor. It listens on a two-wire I2C bus as a slave with one fixed address and accepts command bytes from a bus master. It holds every setting of the signal path in registers: volume, four speaker attenuators, the input selector with its gain and loudness switch, bass and treble. The system clock is much faster than the bus. Both bus lines are first synchronized and filtered. The slave then detects START and STOP, shifts in bits on rising SCL, and acknowledges by pulling SDA low through an output enable.

After a matching address byte, any number of data bytes may follow before the STOP. Each data byte names its target by its leading bits and is applied by itself. The result is presented as plain step counts, which the analog or DSP side can use directly. A one-cycle strobe vector shows which setting group has just changed. A byte that is cut short by a STOP or by a repeated START has no effect.

Top module: `audio_ctrl_i2c`

## Requirements
- R1: Only the address byte 8'h88 (write) is acknowledged. Any other address byte, including 8'h89 and 8'h8A, gets no acknowledge, and the data bytes that follow in the same transfer change no setting and raise no strobe.
- R2: SDA falling while SCL is high begins a transfer, and SDA rising while SCL is high ends it. Bits are taken MSB first on rising SCL. A STOP or a repeated START inside a byte discards that partial byte.
- R3: The slave pulls SDA low (sda_oe=1) through the ninth clock of the address byte and of every data byte. sda_oe changes only while SCL is low.
- R4: Several data bytes in one transfer are each decoded and applied in order, and each one raises its own strobe.
- R5: A byte of the form 00BBBAAA sets vol_steps = 8*BBB + AAA, counted in 1.25 dB steps of attenuation (0..63).
- R6: A byte of the form 1SSBBAAA sets speaker SS to 8*BB + AAA steps on spk_steps[5*SS+4:5*SS]. SS is 0 for left-front, 1 for right-front, 2 for left-rear and 3 for right-rear.
- R7: In a speaker byte, the code BB=11, AAA=111 sets spk_mute[SS]=1 (with steps 31). Every other code clears spk_mute[SS].
- R8: A byte of the form 010GGLSS sets in_sel=SS, loud_en=~L and gain_step=3-GG. gain_step counts 3.75 dB steps, so GG=00 gives +11.25 dB.
- R9: 0110CCCC sets bass_step and 0111CCCC sets treble_step, both signed 2 dB steps. If C3=0 the value is C[2:0]-7; if C3=1 it is 7-C[2:0]. Both 0111 and 1111 give 0.
- R10: Each accepted data byte raises exactly one bit of upd_strobe for exactly one cycle. Bit 0 is volume, bits 1..4 are speakers 0..3, bit 5 is the audio switch, bit 6 is bass and bit 7 is treble. A setting never changes without its strobe bit.
- R11: After reset, vol_steps=63, every speaker reads 31 steps and muted, in_sel=0, gain_step=0, loud_en=0, bass and treble are 0, and sda_oe=0.
- R12: A pulse on SCL shorter than FILT_CYC system clocks is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| vol_steps | output | 6 | Volume attenuation in 1.25 dB steps |
| spk_steps | output | 20 | Four 5-bit speaker attenuations; slice i is speaker i |
| spk_mute | output | 4 | Speaker mute flags |
| in_sel | output | 2 | Selected stereo input minus one |
| gain_step | output | 2 | Input gain in 3.75 dB steps |
| loud_en | output | 1 | Loudness enable |
| bass_step | output | 4 | Signed bass steps of 2 dB |
| treble_step | output | 4 | Signed treble steps of 2 dB |
| upd_strobe | output | 8 | One-cycle marker of the group just written |

## Verification
A bus edge reaches the slave logic two synchronizer cycles plus FILT_CYC filter cycles after it occurs at the pad. The acknowledge enable therefore rises about FILT_CYC+3 cycles after the eighth SCL fall. The settings and their strobe appear one cycle after the slave sees the ninth SCL fall, which is no more than FILT_CYC+5 cycles after that fall at the pad. The bench holds each SCL phase for 15 system clocks, longer than either latency. It samples the acknowledge in the middle of the ninth high phase. It compares the outputs only after the transfer's STOP, when every strobe has already been counted by a monitor that samples on the falling clock edge.

// File: rtl/audio_ctrl_pkg.sv
// Shared constants and helpers for the audio control port.
// Assumes the fixed byte format: widths below are set by the command layout.
package audio_ctrl_pkg;

    localparam int NUM_SPK = 4;
    localparam int VOL_W   = 6;
    localparam int SPK_W   = 5;
    localparam int TONE_W  = 4;
    localparam int UPD_W   = NUM_SPK + 4;

    // Strobe bit positions
    localparam int UPD_VOL  = 0;
    localparam int UPD_SPK0 = 1;
    localparam int UPD_SW   = UPD_SPK0 + NUM_SPK;
    localparam int UPD_BASS = UPD_SW + 1;
    localparam int UPD_TREB = UPD_SW + 2;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_ADDR,
        RX_ADDR_ACK,
        RX_DATA,
        RX_DATA_ACK
    } rx_state_t;

    // Convert a sign/magnitude-style tone code into signed steps
    function automatic logic signed [TONE_W-1:0] tone_steps(input logic [3:0] code);
        logic signed [TONE_W-1:0] mag;
        mag = $signed({1'b0, code[2:0]});
        if (code[3]) return 4'sd7 - mag;
        else         return mag - 4'sd7;
    endfunction

endpackage

// File: rtl/bus_line_filter.sv
// Two-flop synchronizer followed by a stability filter for one bus line.
// The output follows the input only after it has held a new level for
// FILT_CYC consecutive clocks. Assumes the line idles high.
module bus_line_filter #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CNT_W = $clog2(FILT_CYC + 1);

    logic             sync1, sync2;
    logic [CNT_W-1:0] cnt;

    // Bring the asynchronous line into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= din;
            sync2 <= sync1;
        end
    end

    // Accept a new level only after it has been stable long enough
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= 1'b1;
            cnt  <= '0;
        end else if (sync2 == dout) begin
            cnt <= '0;
        end else if (cnt == CNT_W'(FILT_CYC - 1)) begin
            dout <= sync2;
            cnt  <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_byte_rx.sv
// Write-only I2C slave byte engine working on filtered SCL/SDA.
// Detects START/STOP, shifts bits on rising SCL, acknowledges the
// matching address and every data byte, and hands each data byte
// out once its acknowledge clock has ended. Assumes open-drain SDA.
module i2c_byte_rx
    import audio_ctrl_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR = 8'h88
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_f,
    input  logic       sda_f,
    output logic       sda_oe,
    output logic       byte_vld,
    output logic [7:0] byte_q
);
    rx_state_t  state;
    logic       scl_d, sda_d;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic       is_start, is_stop, scl_rise, scl_fall;

    // Bus events seen on the filtered lines
    always_comb begin
        is_start = scl_f && scl_d && sda_d && !sda_f;
        is_stop  = scl_f && scl_d && !sda_d && sda_f;
        scl_rise = scl_f && !scl_d;
        scl_fall = !scl_f && scl_d;
    end

    // Protocol state, bit shifting and acknowledge drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
            bitcnt   <= '0;
            shreg    <= '0;
            sda_oe   <= 1'b0;
            byte_vld <= 1'b0;
            byte_q   <= '0;
        end else begin
            scl_d    <= scl_f;
            sda_d    <= sda_f;
            byte_vld <= 1'b0;
            if (is_start) begin
                state  <= RX_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (is_stop) begin
                state  <= RX_IDLE;
                sda_oe <= 1'b0;
            end else if (scl_rise) begin
                if (state == RX_ADDR || state == RX_DATA) begin
                    shreg  <= {shreg[6:0], sda_f};
                    bitcnt <= bitcnt + 1'b1;
                end
            end else if (scl_fall) begin
                case (state)
                    RX_ADDR: begin
                        if (bitcnt == 4'd8) begin
                            if (shreg == DEV_ADDR) begin
                                sda_oe <= 1'b1;
                                state  <= RX_ADDR_ACK;
                            end else begin
                                state <= RX_IDLE;
                            end
                        end
                    end
                    RX_DATA: begin
                        if (bitcnt == 4'd8) begin
                            sda_oe <= 1'b1;
                            byte_q <= shreg;
                            state  <= RX_DATA_ACK;
                        end
                    end
                    RX_ADDR_ACK: begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        state  <= RX_DATA;
                    end
                    RX_DATA_ACK: begin
                        sda_oe   <= 1'b0;
                        byte_vld <= 1'b1;
                        bitcnt   <= '0;
                        state    <= RX_DATA;
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // R3
    ack_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_f);

    // R3
    ack_fall_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_f);

    // R1
    no_ack_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE) |-> !sda_oe);

endmodule

// File: rtl/cmd_decode.sv
// Decodes each accepted command byte by its leading bits and keeps the
// audio settings. Raises one strobe bit for the group written.
// Assumes byte_vld is a single-cycle pulse.
module cmd_decode
    import audio_ctrl_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       byte_vld,
    input  logic [7:0]                 byte_q,
    output logic [VOL_W-1:0]           vol_steps,
    output logic [NUM_SPK*SPK_W-1:0]   spk_steps,
    output logic [NUM_SPK-1:0]         spk_mute,
    output logic [1:0]                 in_sel,
    output logic [1:0]                 gain_step,
    output logic                       loud_en,
    output logic signed [TONE_W-1:0]   bass_step,
    output logic signed [TONE_W-1:0]   treble_step,
    output logic [UPD_W-1:0]           upd_strobe
);
    logic hit_vol, hit_sw, hit_bass, hit_treb;

    // Prefix classification of the incoming byte
    always_comb begin
        hit_vol  = byte_vld && (byte_q[7:6] == 2'b00);
        hit_sw   = byte_vld && (byte_q[7:5] == 3'b010);
        hit_bass = byte_vld && (byte_q[7:4] == 4'b0110);
        hit_treb = byte_vld && (byte_q[7:4] == 4'b0111);
    end

    // Volume, switch and tone registers with their strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vol_steps           <= '1;
            in_sel              <= '0;
            gain_step           <= '0;
            loud_en             <= 1'b0;
            bass_step           <= '0;
            treble_step         <= '0;
            upd_strobe[UPD_VOL] <= 1'b0;
            upd_strobe[UPD_SW]  <= 1'b0;
            upd_strobe[UPD_BASS] <= 1'b0;
            upd_strobe[UPD_TREB] <= 1'b0;
        end else begin
            upd_strobe[UPD_VOL]  <= hit_vol;
            upd_strobe[UPD_SW]   <= hit_sw;
            upd_strobe[UPD_BASS] <= hit_bass;
            upd_strobe[UPD_TREB] <= hit_treb;
            if (hit_vol)  vol_steps <= byte_q[VOL_W-1:0];
            if (hit_sw) begin
                in_sel    <= byte_q[1:0];
                loud_en   <= ~byte_q[2];
                gain_step <= ~byte_q[4:3];
            end
            if (hit_bass) bass_step   <= tone_steps(byte_q[3:0]);
            if (hit_treb) treble_step <= tone_steps(byte_q[3:0]);
        end
    end

    // One attenuator per speaker output
    for (genvar i = 0; i < NUM_SPK; i++) begin : g_spk
        logic hit_spk;
        always_comb hit_spk = byte_vld && byte_q[7] && (byte_q[6:5] == 2'(i));

        // Hold this speaker's attenuation and mute flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                spk_steps[i*SPK_W +: SPK_W] <= '1;
                spk_mute[i]                 <= 1'b1;
                upd_strobe[UPD_SPK0 + i]    <= 1'b0;
            end else begin
                upd_strobe[UPD_SPK0 + i] <= hit_spk;
                if (hit_spk) begin
                    spk_steps[i*SPK_W +: SPK_W] <= byte_q[SPK_W-1:0];
                    spk_mute[i]                 <= (byte_q[4:0] == 5'h1F);
                end
            end
        end

        // R10
        spk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !upd_strobe[UPD_SPK0 + i] |-> ($stable(spk_steps[i*SPK_W +: SPK_W]) && $stable(spk_mute[i])));
    end

    // R10
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upd_strobe));

    // R10
    vol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_strobe[UPD_VOL] |-> $stable(vol_steps));

    // R9
    tone_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bass_step != -4'sd8) && (treble_step != -4'sd8));

    // R10
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_strobe != '0) |=> (upd_strobe == '0));

endmodule

// File: rtl/audio_ctrl_i2c.sv
// Top of the audio control port: filters the bus lines, runs the
// write-only slave and decodes commands into setting registers.
// Assumes clk is at least a few dozen times faster than SCL.
module audio_ctrl_i2c
    import audio_ctrl_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR = 8'h88,
    parameter int         FILT_CYC = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    output logic [5:0]  vol_steps,
    output logic [19:0] spk_steps,
    output logic [3:0]  spk_mute,
    output logic [1:0]  in_sel,
    output logic [1:0]  gain_step,
    output logic        loud_en,
    output logic [3:0]  bass_step,
    output logic [3:0]  treble_step,
    output logic [7:0]  upd_strobe
);
    logic       scl_f, sda_f;
    logic       byte_vld;
    logic [7:0] byte_q;

    bus_line_filter #(.FILT_CYC(FILT_CYC)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_f));

    bus_line_filter #(.FILT_CYC(FILT_CYC)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_f));

    i2c_byte_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .sda_oe(sda_oe), .byte_vld(byte_vld), .byte_q(byte_q));

    cmd_decode u_dec (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_q(byte_q),
        .vol_steps(vol_steps), .spk_steps(spk_steps), .spk_mute(spk_mute),
        .in_sel(in_sel), .gain_step(gain_step), .loud_en(loud_en),
        .bass_step(bass_step), .treble_step(treble_step),
        .upd_strobe(upd_strobe));

endmodule

// File: tb/sim_audio_ctrl_i2c.sv
// Self-checking bench: bus master tasks, a reference model of the
// settings, directed corner cases and seeded random command bytes.
module sim_audio_ctrl_i2c;
    localparam int Q = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, scl_g = 1'b0;
    logic sda_oe;
    logic [5:0]  vol_steps;
    logic [19:0] spk_steps;
    logic [3:0]  spk_mute;
    logic [1:0]  in_sel, gain_step;
    logic        loud_en;
    logic [3:0]  bass_step, treble_step;
    logic [7:0]  upd_strobe;
    wire scl_line = scl_m | scl_g;
    wire sda_line = sda_m & ~sda_oe;

    int n_checks = 0, n_err = 0;
    int strobe_cnt = 0, wide_err = 0;
    logic [7:0] last_upd = '0, prev_upd = '0;

    int m_vol, m_in, m_gain, m_loud, m_bass, m_treb;
    int m_spk [4];
    int m_mute [4];

    always #5 clk = ~clk;

    audio_ctrl_i2c u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .sda_oe(sda_oe), .vol_steps(vol_steps), .spk_steps(spk_steps),
        .spk_mute(spk_mute), .in_sel(in_sel), .gain_step(gain_step),
        .loud_en(loud_en), .bass_step(bass_step), .treble_step(treble_step),
        .upd_strobe(upd_strobe));

    // Strobe monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (upd_strobe != 8'h00) begin
                strobe_cnt++;
                last_upd = upd_strobe;
                if (prev_upd != 8'h00) wide_err++;
            end
            prev_upd = upd_strobe;
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int tone_ref(input int c);
        if (c >= 8) return 7 - (c - 8);
        return c - 7;
    endfunction

    // Reference model: apply a byte, return the strobe bit expected
    function automatic int model_apply(input logic [7:0] b);
        if (b[7]) begin
            m_spk[b[6:5]]  = int'(b[4:0]);
            m_mute[b[6:5]] = (b[4:0] == 5'h1F) ? 1 : 0;
            return 1 + int'(b[6:5]);
        end else if (b[6] == 1'b0) begin
            m_vol = int'(b[5:0]);
            return 0;
        end else if (b[5] == 1'b0) begin
            m_in   = int'(b[1:0]);
            m_loud = b[2] ? 0 : 1;
            m_gain = 3 - int'(b[4:3]);
            return 5;
        end else if (b[4] == 1'b0) begin
            m_bass = tone_ref(int'(b[3:0]));
            return 6;
        end
        m_treb = tone_ref(int'(b[3:0]));
        return 7;
    endfunction

    function automatic string req_of(input int bitn);
        case (bitn)
            0: return "R5";
            1, 2, 3, 4: return "R6/R7";
            5: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check_outputs(input string req);
        check(vol_steps == 6'(m_vol), req, "vol_steps", int'(vol_steps), m_vol);
        for (int i = 0; i < 4; i++) begin
            check(spk_steps[i*5 +: 5] == 5'(m_spk[i]), req, "spk_steps", int'(spk_steps[i*5 +: 5]), m_spk[i]);
            check(spk_mute[i] == m_mute[i][0], req, "spk_mute", int'(spk_mute[i]), m_mute[i]);
        end
        check(in_sel == 2'(m_in), req, "in_sel", int'(in_sel), m_in);
        check(gain_step == 2'(m_gain), req, "gain_step", int'(gain_step), m_gain);
        check(loud_en == m_loud[0], req, "loud_en", int'(loud_en), m_loud);
        check($signed(bass_step) == m_bass, req, "bass_step", int'($signed(bass_step)), m_bass);
        check($signed(treble_step) == m_treb, req, "treble_step", int'($signed(treble_step)), m_treb);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        sda_m = b;
        if (glitch) begin
            tick(4); scl_g = 1'b1; tick(2); scl_g = 1'b0; tick(Q - 6);
        end else begin
            tick(Q);
        end
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0;
        tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i], glitch && (i == 4));
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        acked = !sda_line;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    // Full single-byte write with every check
    task automatic write_one(input logic [7:0] b, input bit glitch);
        bit a0, a1;
        int c0, exp_bit;
        c0 = strobe_cnt;
        bus_start();
        send_byte(8'h88, 1'b0, a0);
        send_byte(b, glitch, a1);
        bus_stop();
        exp_bit = model_apply(b);
        check(a0, "R1", "address ack", int'(a0), 1);
        check(a1, "R3", "data ack", int'(a1), 1);
        check(strobe_cnt - c0 == 1, "R10", "strobe count", strobe_cnt - c0, 1);
        check(last_upd == 8'(1 << exp_bit), "R10", "strobe bit", int'(last_upd), 1 << exp_bit);
        check_outputs(glitch ? "R12" : req_of(exp_bit));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        bit a0, a1, a2;
        int c0;
        void'($urandom(32'd2024));
        m_vol = 63; m_in = 0; m_gain = 0; m_loud = 0; m_bass = 0; m_treb = 0;
        for (int i = 0; i < 4; i++) begin m_spk[i] = 31; m_mute[i] = 1; end
        tick(5);
        rst_n = 1'b1;
        tick(3);

        // R11: reset defaults
        check_outputs("R11");
        check(sda_oe == 1'b0, "R11", "sda_oe", int'(sda_oe), 0);
        check(upd_strobe == 8'h00, "R11", "upd_strobe", int'(upd_strobe), 0);

        // Directed examples and code corners
        write_one(8'h24, 1'b0);   // R5: 45 dB -> 36 steps
        write_one(8'h3F, 1'b0);   // R5: maximum
        write_one(8'hB4, 1'b0);   // R6: right-front 25 dB
        write_one(8'hFF, 1'b0);   // R7: right-rear mute
        write_one(8'hFE, 1'b0);   // R7: right-rear 30 steps, not muted
        write_one(8'h80, 1'b0);   // R6: left-front 0 dB
        write_one(8'h49, 1'b0);   // R8: input 2, +7.5 dB, loudness on
        write_one(8'h5F, 1'b0);   // R8: input 4, 0 dB, loudness off
        write_one(8'h62, 1'b0);   // R9: bass -5
        write_one(8'h77, 1'b0);   // R9: treble zero code 0111
        write_one(8'h78, 1'b0);   // R9: treble +7
        write_one(8'h7F, 1'b0);   // R9: treble zero code 1111
        write_one(8'h60, 1'b0);   // R9: bass -7
        write_one(8'h11, 1'b1);   // R12: glitch on SCL inside the byte

        // R1: read-direction and foreign addresses are ignored
        c0 = strobe_cnt;
        bus_start();
        send_byte(8'h89, 1'b0, a0);
        send_byte(8'h00, 1'b0, a1);
        bus_stop();
        bus_start();
        send_byte(8'h8A, 1'b0, a2);
        send_byte(8'hC0, 1'b0, a1);
        bus_stop();
        check(!a0, "R1", "ack on 0x89", int'(a0), 0);
        check(!a2, "R1", "ack on 0x8A", int'(a2), 0);
        check(strobe_cnt == c0, "R1", "strobes after bad address", strobe_cnt - c0, 0);
        check_outputs("R1");

        // R2: STOP inside a data byte discards it
        c0 = strobe_cnt;
        bus_start();
        send_byte(8'h88, 1'b0, a0);
        for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b0);
        bus_stop();
        check(strobe_cnt == c0, "R2", "strobes after stop mid-byte", strobe_cnt - c0, 0);
        check_outputs("R2");

        // R2: repeated START inside a data byte, then a full write
        c0 = strobe_cnt;
        bus_start();
        send_byte(8'h88, 1'b0, a0);
        for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b0);
        bus_start();
        send_byte(8'h88, 1'b0, a0);
        send_byte(8'h2F, 1'b0, a1);
        bus_stop();
        void'(model_apply(8'h2F));
        check(a0 && a1, "R2", "acks after repeated start", int'(a0 && a1), 1);
        check(strobe_cnt - c0 == 1, "R2", "strobes after repeated start", strobe_cnt - c0, 1);
        check_outputs("R2");

        // R4: several data bytes in one transfer
        c0 = strobe_cnt;
        bus_start();
        send_byte(8'h88, 1'b0, a0);
        send_byte(8'h0A, 1'b0, a1);
        send_byte(8'hD3, 1'b0, a2);
        send_byte(8'h6C, 1'b0, a2);
        bus_stop();
        void'(model_apply(8'h0A));
        void'(model_apply(8'hD3));
        check(model_apply(8'h6C) == 6 && last_upd == 8'h40, "R4", "last strobe", int'(last_upd), 8'h40);
        check(strobe_cnt - c0 == 3, "R4", "strobes in multi-byte", strobe_cnt - c0, 3);
        check_outputs("R4");

        // Seeded random command bytes
        for (int k = 0; k < 40; k++) write_one(8'($urandom), 1'b0);

        check(wide_err == 0, "R10", "wide strobes", wide_err, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule